// File: doc/BRIEF.md
# Twenty-Four Stage Binary Divider With Split Test Mode

This block divides an incoming pulse stream by powers of two through a 24-stage chain of halving stages. Each stage runs at half the rate of the stage below it, so the whole chain holds 2^24 = 16,777,216 distinct states. Only the seven most significant stages reach the output. They give division ratios of 2^18 through 2^24. An active-high asynchronous reset forces every stage low and overrides all counting.

In normal (serial) mode the chain advances once on every high-to-low transition of the pulse input. When the test select is high, the chain is cut into three 8-stage sections. All three sections are fed in parallel from the same pulse input, and they advance on the low-to-high transition instead. After reset, 255 test pulses fill every stage with ones. Clearing the test select then puts the chain back into series, and one more normal pulse makes it roll over from all ones to all zeros. The chain is built as a synchronous counter on a free-running clock. That clock samples the pulse input and turns the edge that the mode selects into a one-cycle count strobe.

Top module: `divchain_top`

## Requirements
- R1: While `rst` is high, all 24 stages read zero at once, with no clock edge needed.
- R2: With `testSel` low, each high-to-low transition of `pulseIn` adds one to the 24-bit state, modulo 2^24. A low-to-high transition leaves the state unchanged.
- R3: With `testSel` high, each low-to-high transition of `pulseIn` adds one, modulo 256, to each of the three 8-bit sections (bits 7:0, 15:8 and 23:16) on its own. A high-to-low transition leaves the state unchanged.
- R4: In serial mode a carry crosses the section boundaries, so that state 255 steps to 256 and state 65535 steps to 65536.
- R5: `taps[6:0]` always equals bits 23:17 of the state, which are stages 18 through 24.
- R6: Starting from reset, 255 test-mode pulses leave all 24 stages high (0xFFFFFF).
- R7: From the all-ones state, after a return to serial mode, a single normal pulse brings the state to zero.
- R8: Transitions of `pulseIn` while `rst` is high have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; its rate must be well above the pulse rate |
| rst | input | 1 | Asynchronous master clear, active high |
| pulseIn | input | 1 | Pulse stream to be divided |
| testSel | input | 1 | High selects the three-section parallel mode |
| taps | output | 7 | Outputs of stages 18 to 24 |
| stateObs | output | 24 | Full state of the chain, for observation |

## Verification
The assertions assume that `pulseIn` and `testSel` change no faster than one level per two clock cycles. Under that assumption every counting transition shows up as exactly one strobe. They also assume that `testSel` changes only while `pulseIn` is stable, so that a change of mode never creates a false edge. The stimulus holds every level of `pulseIn` for four clock cycles. It changes `testSel` only while `pulseIn` sits low, and it waits two quiet cycles after each change of mode or release of reset before the next edge.

// File: rtl/divchain_pkg.sv
package divchain_pkg;
  // strobes from the edge control to the stage datapath
  typedef struct packed {
    logic step;   // one-cycle advance request
    logic split;  // sections advance independently
  } chainCtrl_t;
endpackage

// File: rtl/divchain_ctrl.sv
module divchain_ctrl
  import divchain_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pulseIn,
  input  logic       testSel,
  output chainCtrl_t ctrlOut
);
  logic sampleNow;
  logic samplePrev;
  logic splitQ;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sampleNow  <= 1'b0;
      samplePrev <= 1'b0;
      splitQ     <= 1'b0;
    end else begin
      sampleNow  <= pulseIn;
      samplePrev <= sampleNow;
      splitQ     <= testSel;
    end
  end

  logic riseSeen;
  logic fallSeen;
  assign riseSeen = sampleNow & ~samplePrev;
  assign fallSeen = ~sampleNow & samplePrev;

  always_comb begin
    ctrlOut.split = splitQ;
    ctrlOut.step  = splitQ ? riseSeen : fallSeen;
  end
endmodule

// File: rtl/divchain_dp.sv
module divchain_dp
  import divchain_pkg::*;
#(
  parameter int STAGES   = 24,
  parameter int SECTIONS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  chainCtrl_t        ctrlIn,
  output logic [STAGES-1:0] count
);
  localparam int SEC_W = STAGES / SECTIONS;

  logic [SECTIONS-1:0][SEC_W-1:0] secVal;
  logic [SECTIONS:0]              carry;

  assign carry[0] = ctrlIn.step;

  for (genvar g = 0; g < SECTIONS; g++) begin : g_sec
    logic [SEC_W-1:0] secReg;
    logic             secEn;

    assign carry[g+1] = carry[g] & (&secReg);
    assign secEn      = ctrlIn.split ? ctrlIn.step : carry[g];

    always_ff @(posedge clk or posedge rst) begin
      if (rst)        secReg <= '0;
      else if (secEn) secReg <= secReg + 1'b1;
    end

    assign secVal[g] = secReg;
  end

  assign count = secVal;
endmodule

// File: rtl/divchain_top.sv
module divchain_top
  import divchain_pkg::*;
#(
  parameter int STAGES   = 24,
  parameter int SECTIONS = 3,
  parameter int TAPS     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulseIn,
  input  logic              testSel,
  output logic [TAPS-1:0]   taps,
  output logic [STAGES-1:0] stateObs
);
  chainCtrl_t chainCtl;

  divchain_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .pulseIn (pulseIn),
    .testSel (testSel),
    .ctrlOut (chainCtl)
  );

  divchain_dp #(
    .STAGES   (STAGES),
    .SECTIONS (SECTIONS)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrlIn (chainCtl),
    .count  (stateObs)
  );

  assign taps = stateObs[STAGES-1 -: TAPS];
endmodule

// File: rtl/divchain_chk.sv
module divchain_chk #(
  parameter int STAGES   = 24,
  parameter int SECTIONS = 3,
  parameter int TAPS     = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              step,
  input logic              split,
  input logic [STAGES-1:0] stateObs
);
  localparam int SEC_W = STAGES / SECTIONS;

  // R1: reset clears the chain
  a_r1_clear_in_reset: assert property (@(posedge clk) rst |-> stateObs == '0);

  // R2 / R4: serial strobe adds one across all sections
  a_r2_serial_step: assert property (@(posedge clk) disable iff (rst)
    (step && !split) |=> stateObs == $past(stateObs) + 1'b1);

  // R8 / R2 / R3: no strobe, no change
  a_r8_hold_without_step: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(stateObs));

  // R3: each section wraps on its own in split mode
  for (genvar g = 0; g < SECTIONS; g++) begin : g_chk
    a_r3_section_step: assert property (@(posedge clk) disable iff (rst)
      (step && split) |=>
        stateObs[g*SEC_W +: SEC_W] == $past(stateObs[g*SEC_W +: SEC_W]) + 1'b1);
  end
endmodule

bind divchain_top divchain_chk #(
  .STAGES   (STAGES),
  .SECTIONS (SECTIONS),
  .TAPS     (TAPS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .step     (chainCtl.step),
  .split    (chainCtl.split),
  .stateObs (stateObs)
);

// File: tb/tb_divchain_top.sv
module tb_divchain_top;
  localparam int PERIOD = 10;
  localparam int WATCH  = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        pulseIn;
  logic        testSel;
  logic [6:0]  taps;
  logic [23:0] stateObs;
  logic [23:0] model;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(PERIOD/2) clk = ~clk;

  divchain_top dut (
    .clk(clk), .rst(rst), .pulseIn(pulseIn), .testSel(testSel),
    .taps(taps), .stateObs(stateObs)
  );

  task automatic check(input string req, input logic [23:0] exp);
    total++;
    if (stateObs !== exp) begin
      bad++;
      $display("FAIL %s state actual=%h expected=%h", req, stateObs, exp);
    end
    total++;
    if (taps !== exp[23:17]) begin  // R5
      bad++;
      $display("FAIL R5 taps actual=%h expected=%h", taps, exp[23:17]);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic serialPulse(input string req);
    pulseIn = 1'b1; idle(4);
    check("R2", model);                 // rising edge ignored
    pulseIn = 1'b0; idle(4);
    model = model + 24'd1;
    check(req, model);
  endtask

  task automatic splitPulse(input string req);
    pulseIn = 1'b1; idle(4);
    for (int s = 0; s < 3; s++) model[s*8 +: 8] = model[s*8 +: 8] + 8'd1;
    check(req, model);
    pulseIn = 1'b0; idle(4);
    check("R3", model);                 // falling edge ignored
  endtask

  task automatic doReset();
    rst = 1'b1; idle(2);
    rst = 1'b0; idle(2);
    model = '0;
  endtask

  initial begin
    #(PERIOD*WATCH);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pulseIn = 1'b0; testSel = 1'b0; model = '0;
    idle(3);
    check("R1", 24'd0);
    // R8: pulses during reset have no effect
    for (int i = 0; i < 3; i++) begin
      pulseIn = 1'b1; idle(4); pulseIn = 1'b0; idle(4);
      check("R8", 24'd0);
    end
    rst = 1'b0; idle(2);

    // R2/R4: serial count across the first section boundary
    for (int i = 0; i < 300; i++) serialPulse((model == 24'd255) ? "R4" : "R2");

    // R1: asynchronous clear between edges
    @(posedge clk); #3; rst = 1'b1; #1;
    model = '0;
    check("R1", 24'd0);
    idle(2); rst = 1'b0; idle(2);

    // R3/R6: parallel fill
    testSel = 1'b1; idle(2);
    for (int i = 0; i < 255; i++) splitPulse("R3");
    check("R6", 24'hFFFFFF);

    // R7: back to serial, one pulse rolls over
    testSel = 1'b0; idle(2);
    check("R7", 24'hFFFFFF);
    serialPulse("R7");
    check("R7", 24'd0);

    // R4/R5: preload 0xFEFEFE by split pulses, then count serially
    doReset();
    testSel = 1'b1; idle(2);
    for (int i = 0; i < 254; i++) splitPulse("R3");
    testSel = 1'b0; idle(2);
    for (int i = 0; i < 600; i++)
      serialPulse((model[15:0] == 16'hFFFF) ? "R4" : "R2");
    check("R4", 24'hFF0156);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule